// File: doc/BRIEF.md
# Frame Buffer Data Port for a Network MAC

This block sits between a register bus and the frame buffers of a network MAC. Software moves frames one 32-bit word at a time through a single data port. A bus write appends a word to the transmit buffer. A bus read takes the next word from the receive buffer. Neither buffer can be addressed at random, and a word that has been read cannot be read again.

On the transmit side, the first word of each frame carries the frame length. The block uses this length to decide how many words belong to the frame. Extra words are dropped. A frame with too few words is still sent at its full length. Once software pulses the start strobe, the frame drains through a valid/ready stream. Until the last word has gone, the transmit side stays busy and refuses new writes. A clear strobe lets software discard a frame it has only partly loaded and begin again.

On the receive side, the MAC pushes words together with an end-of-frame marker. Software can only read words that belong to frames that have fully arrived.

Top module: `mac_fifo_port`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_rdata`, `tx_busy` and `tx_out_valid` are all zero.
- R2: Accepted bus writes are stored at consecutive buffer positions starting at position 0. The frame is streamed on `tx_out_data` in that order, one word for each cycle in which `tx_out_valid` and `tx_out_ready` are both high.
- R3: Bits 15:0 of the first word of a frame give its length L in bytes. The frame is N = min(ceil((L+2)/4), 128) words long. After `tx_start`, exactly N words are streamed, and `tx_busy` falls in the cycle after the Nth handshake.
- R4: Writes beyond the Nth word of a frame are dropped. They do not change any buffer position that is sent.
- R5: If fewer than N words were written, N words are still sent. Each missing position carries whatever word that buffer position last held.
- R6: While `tx_busy` is high, bus writes are discarded. Once the frame ends, the next write becomes word 0 of a new frame.
- R7: A `tx_clr` pulse while not busy resets the write position to 0. The next write then starts a new frame with a new length.
- R8: `tx_start` is ignored if no word has been written since the last frame or clear. It is also ignored while busy.
- R9: A bus read from a completed receive frame returns that word on `rsp_rdata`, with `rsp_valid` high, one cycle later. It then advances to the next word.
- R10: A bus read when no completed receive word is waiting returns zero and does not advance the read position.
- R11: Words of a receive frame cannot be read until the word marked with `rx_in_last` has been accepted.
- R12: Both receive positions wrap modulo the 128-word depth. Traffic totalling more than 128 words comes out in order.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write (transmit push), 0 = read (receive pop) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted (always high) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| tx_start | input | 1 | Begin sending the loaded frame |
| tx_clr | input | 1 | Return the transmit write position to 0 |
| tx_busy | output | 1 | Frame is being sent |
| tx_out_valid | output | 1 | Transmit word available |
| tx_out_ready | input | 1 | Transmit side takes the word |
| tx_out_data | output | 32 | Transmit word |
| rx_in_valid | input | 1 | Receive word strobe |
| rx_in_last | input | 1 | Marks the final word of a receive frame |
| rx_in_data | input | 32 | Receive word |

## Verification
Transmit frames are loaded in four ways: with exactly N words, with more than N, with fewer than N, and with extra writes made while the previous frame is still draining. Comparing the streamed words against a model of the buffer contents separates correct length gating from padding with stale data and from writes that slip in while busy. Receive reads are made before any frame has arrived, in the middle of a frame and after its end marker, which shows whether availability is gated at frame boundaries. A run of several 40-word frames carries both receive pointers past the end of the buffer.

// File: rtl/mac_fifo_port.sv
`timescale 1ns/1ps
module mac_fifo_port #(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  parameter int LENW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          tx_start,
  input  logic          tx_clr,
  output logic          tx_busy,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  input  logic          rx_in_last,
  input  logic [DW-1:0] rx_in_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];

  logic [CW-1:0] tx_wcnt, tx_need, tx_rcnt;
  logic          tx_busy_q;
  logic [CW-1:0] rx_wp, rx_cp, rx_rp;

  logic [LENW:0] words_raw;
  logic [CW-1:0] need_new;
  logic wr, rd, tx_go, tx_accept, tx_fire, tx_done;
  logic rx_full, rx_take, rx_has;

  assign wr        = bus_valid & bus_write;
  assign rd        = bus_valid & ~bus_write;
  assign bus_ready = 1'b1;

  assign words_raw = ({1'b0, bus_wdata[LENW-1:0]} + (LENW+1)'(5)) >> 2;
  assign need_new  = (words_raw > (LENW+1)'(DEPTH)) ? CW'(DEPTH) : words_raw[CW-1:0];

  assign tx_go     = tx_start & ~tx_busy_q & (tx_wcnt != '0);
  assign tx_accept = wr & ~tx_busy_q & ~tx_clr & ~tx_go &
                     ((tx_wcnt == '0) | (tx_wcnt < tx_need));
  assign tx_fire   = tx_busy_q & tx_out_ready;
  assign tx_done   = tx_fire & (tx_rcnt == tx_need - 1'b1);

  assign tx_busy      = tx_busy_q;
  assign tx_out_valid = tx_busy_q;
  assign tx_out_data  = tx_mem[tx_rcnt[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wcnt   <= '0;
      tx_need   <= '0;
      tx_rcnt   <= '0;
      tx_busy_q <= 1'b0;
    end else begin
      if (tx_done) begin
        tx_busy_q <= 1'b0;
        tx_wcnt   <= '0;
      end else if (tx_clr && !tx_busy_q) begin
        tx_wcnt <= '0;
      end else if (tx_accept) begin
        tx_wcnt <= tx_wcnt + 1'b1;
        if (tx_wcnt == '0) tx_need <= need_new;
      end
      if (tx_go) begin
        tx_busy_q <= 1'b1;
        tx_rcnt   <= '0;
      end else if (tx_fire) begin
        tx_rcnt <= tx_rcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_accept) tx_mem[tx_wcnt[AW-1:0]] <= bus_wdata;
    if (rx_take)   rx_mem[rx_wp[AW-1:0]]   <= rx_in_data;
  end

  assign rx_full = (rx_wp - rx_rp) == CW'(DEPTH);
  assign rx_take = rx_in_valid & ~rx_full;
  assign rx_has  = rx_rp != rx_cp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp     <= '0;
      rx_cp     <= '0;
      rx_rp     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (rx_take) rx_wp <= rx_wp + 1'b1;
      if (rx_in_valid && rx_in_last) rx_cp <= rx_take ? rx_wp + 1'b1 : rx_wp;
      rsp_valid <= rd;
      if (rd) begin
        if (rx_has) begin
          rsp_rdata <= rx_mem[rx_rp[AW-1:0]];
          rx_rp     <= rx_rp + 1'b1;
        end else begin
          rsp_rdata <= '0;
        end
      end
    end
  end
endmodule

module mac_fifo_port_chk #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          tx_start,
  input logic          tx_busy,
  input logic          tx_out_ready,
  input logic [CW-1:0] tx_wcnt,
  input logic [CW-1:0] tx_need,
  input logic [CW-1:0] rx_wp,
  input logic [CW-1:0] rx_cp,
  input logic [CW-1:0] rx_rp
);
  assert_len_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wcnt <= tx_need);

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && bus_valid && bus_write && !tx_out_ready) |=> $stable(tx_wcnt));

  assert_start_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_start));

  assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> ($past(tx_out_ready) && tx_wcnt == '0));

  assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && rx_rp == rx_cp) |=> (rsp_rdata == '0 && $stable(rx_rp)));

  assert_commit_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(rx_cp - rx_rp)) <= (CW'(rx_wp - rx_rp)));
endmodule

bind mac_fifo_port mac_fifo_port_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tx_start(tx_start),
  .tx_busy(tx_busy), .tx_out_ready(tx_out_ready), .tx_wcnt(tx_wcnt),
  .tx_need(tx_need), .rx_wp(rx_wp), .rx_cp(rx_cp), .rx_rp(rx_rp)
);

// File: tb/test_mac_fifo_port.sv
`timescale 1ns/1ps
module test_mac_fifo_port;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [31:0] bus_wdata = 0;
  logic bus_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic tx_start = 0, tx_clr = 0, tx_busy, tx_out_valid;
  logic tx_out_ready = 0;
  logic [31:0] tx_out_data;
  logic rx_in_valid = 0, rx_in_last = 0;
  logic [31:0] rx_in_data = 0;

  mac_fifo_port i_mac_fifo_port (.*);

  always #2 clk = ~clk;

  int checks = 0, failures = 0, tx_seen = 0, cyc = 0;
  bit hold = 0;
  logic [31:0] rd_q[$];  string rd_tag[$];
  logic [31:0] tx_q[$];  bit tx_care[$]; string tx_tag[$];
  logic [31:0] model [128];
  bit known [128];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    tx_out_ready = !hold && (cyc % 3 != 1);
  end

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      if (rd_q.size() == 0) check(0, "R9 unexpected read response", rsp_rdata, 0);
      else begin
        logic [31:0] e; string t;
        e = rd_q.pop_front(); t = rd_tag.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
    if (tx_out_valid && tx_out_ready) begin
      tx_seen++;
      if (tx_q.size() == 0) check(0, "R3 extra transmit word", tx_out_data, 0);
      else begin
        logic [31:0] e; bit c; string t;
        e = tx_q.pop_front(); c = tx_care.pop_front(); t = tx_tag.pop_front();
        if (c) check(tx_out_data === e, t, tx_out_data, e);
      end
    end
  end

  task automatic bus_wr(logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(logic [31:0] exp, string tag);
    rd_q.push_back(exp); rd_tag.push_back(tag);
    bus_valid = 1; bus_write = 0;
    @(posedge clk); #1;
    bus_valid = 0;
  endtask

  task automatic rx_push(logic [31:0] d, bit last);
    rx_in_valid = 1; rx_in_last = last; rx_in_data = d;
    @(posedge clk); #1;
    rx_in_valid = 0; rx_in_last = 0;
  endtask

  task automatic pulse_start();
    tx_start = 1; @(posedge clk); #1; tx_start = 0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && tx_busy; g++) @(posedge clk);
    #1;
  endtask

  function automatic int need_of(int len);
    int n = (len + 5) / 4;
    return (n > 128) ? 128 : n;
  endfunction

  task automatic load(int len, int nw, logic [31:0] base);
    int n = need_of(len);
    for (int i = 0; i < nw; i++) begin
      logic [31:0] d = (i == 0) ? {base[15:0], 16'(len)} : base + 32'(i);
      bus_wr(d);
      if (i < n) begin model[i] = d; known[i] = 1; end
    end
  endtask

  task automatic expect_frame(int n, string tag);
    for (int i = 0; i < n; i++) begin
      tx_q.push_back(model[i]); tx_care.push_back(known[i]); tx_tag.push_back(tag);
    end
    tx_seen = 0;
  endtask

  task automatic finish_frame(int n, string tag);
    wait_idle();
    repeat (2) @(posedge clk); #1;
    check(tx_seen == n, {tag, " word count"}, 32'(tx_seen), 32'(n));
    check(tx_busy == 0, {tag, " busy cleared"}, 32'(tx_busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) known[i] = 0;
    repeat (5) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 0, "R1 rsp_valid", 32'(rsp_valid), 0);
    check(rsp_rdata == 0, "R1 rsp_rdata", rsp_rdata, 0);
    check(tx_busy == 0, "R1 tx_busy", 32'(tx_busy), 0);
    check(tx_out_valid == 0, "R1 tx_out_valid", 32'(tx_out_valid), 0);
    @(posedge clk); #1;

    // R2 R3: exact-length frame, 30 bytes -> 8 words
    load(30, 8, 32'h1100_0000);
    expect_frame(8, "R2 exact frame");
    pulse_start();
    finish_frame(8, "R3 exact frame");

    // R3: 10 bytes -> 3 words
    load(10, 3, 32'h2200_0000);
    expect_frame(3, "R3 short length");
    pulse_start();
    finish_frame(3, "R3 short length");

    // R4: 6 bytes -> 2 words, 5 written
    load(6, 5, 32'h3300_0000);
    expect_frame(2, "R4 excess dropped");
    pulse_start();
    finish_frame(2, "R4 excess dropped");

    // R5: 20 bytes -> 6 words, 2 written; rest is stale buffer content
    load(20, 2, 32'h4400_0000);
    expect_frame(6, "R5 padding");
    pulse_start();
    finish_frame(6, "R5 padding");

    // R6: writes while busy are discarded
    hold = 1;
    load(30, 4, 32'h5500_0000);
    expect_frame(8, "R6 busy writes");
    pulse_start();
    check(tx_busy == 1, "R6 busy raised", 32'(tx_busy), 1);
    for (int i = 0; i < 4; i++) bus_wr(32'hDEAD_0000 + 32'(i));
    hold = 0;
    finish_frame(8, "R6 busy writes");

    // R8: start with nothing loaded is ignored
    pulse_start();
    @(posedge clk); #1;
    check(tx_busy == 0, "R8 empty start", 32'(tx_busy), 0);

    // R7: clear discards partial frame
    bus_wr(32'h6600_0050); bus_wr(32'h6600_0001);
    model[0] = 32'h6600_0050; model[1] = 32'h6600_0001;
    tx_clr = 1; @(posedge clk); #1; tx_clr = 0;
    load(2, 1, 32'h7700_0000);
    expect_frame(1, "R7 clear restart");
    pulse_start();
    finish_frame(1, "R7 clear restart");

    // R10: read with nothing received
    bus_rd(32'h0, "R10 empty read");
    // R11: partial frame not readable
    rx_push(32'hA000_0001, 0);
    rx_push(32'hA000_0002, 0);
    bus_rd(32'h0, "R11 frame in progress");
    rx_push(32'hA000_0003, 1);
    // R9: sequential reads after commit
    bus_rd(32'hA000_0001, "R9 read word 0");
    bus_rd(32'hA000_0002, "R9 read word 1");
    bus_rd(32'hA000_0003, "R9 read word 2");
    bus_rd(32'h0, "R10 drained read");

    // R12: wrap across depth
    for (int f = 0; f < 5; f++) begin
      for (int i = 0; i < 40; i++) rx_push({8'hB0 + 8'(f), 24'(i)}, i == 39);
      for (int i = 0; i < 40; i++) bus_rd({8'hB0 + 8'(f), 24'(i)}, "R12 wrap order");
    end

    repeat (4) @(posedge clk); #1;
    check(rd_q.size() == 0, "R9 responses all seen", 32'(rd_q.size()), 0);
    check(tx_q.size() == 0, "R3 words all seen", 32'(tx_q.size()), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule